// File: doc/BRIEF.md
# Odd-Byte Chained Move Word Packer

This block turns a list of byte segments read from memory into 16-bit words for a wide parallel peripheral bus. Each segment arrives as a move command that carries a 24-bit byte count, a 32-bit start address, the bus phase the move expects, and a flag that marks the move as chained. After the command is accepted, bytes stream in one at a time over a valid/ready port. They are paired into words, low byte first, and sent out over a registered valid/ready port.

When a chained move ends on an odd byte, that byte is not padded. The block holds it and pairs it with the first byte of the next move, so a list of scatter/gather segments reaches the bus as one unbroken word stream. The software places the chained form on every segment except the last. The last segment uses the plain form. If a plain move ends on an odd byte, the block sends that byte with a zero upper byte and raises a pad flag.

The block checks the expected phase against the live bus phase when it accepts a command. On a mismatch it raises a one-cycle interrupt and moves no data. When a move is finished, a one-cycle done pulse lets the next command be fetched. A clear input abandons the current move and drops any held byte.

Top module: `oddbyte_word_packer`

## Requirements
- R1: Reset state. After a synchronous reset, out_valid, hold_valid, pad_flag, done and phase_irq are all 0. cmd_ready is 1 and in_ready is 0.
- R2: Byte order. Bytes are packed in the order they are accepted. The earlier byte of a pair goes in out_word[7:0] and the later byte goes in out_word[15:8].
- R3: Chained odd tail. A chained move (cmd_chain=1) whose bytes leave one byte unpaired sends no word for that byte. The block holds it and sets hold_valid to 1 after the move.
- R4: Held byte first. A held byte is sent before any new byte. It sits in out_word[7:0], and the first byte of the next move sits in out_word[15:8].
- R5: Plain odd tail. A plain move (cmd_chain=0) that ends with one unpaired byte sends out_word = {8'h00, byte}. It sets pad_flag to 1, and pad_flag stays 1 until the next command is accepted. hold_valid is then 0.
- R6: Phase mismatch. A command whose cmd_phase differs from bus_phase at acceptance produces a one-cycle phase_irq in the cycle after acceptance. No byte is taken, no done pulse follows, and hold_valid is unchanged.
- R7: Done timing. done is a one-cycle pulse. It comes in the cycle after the final byte of a move is accepted. For a zero-count command it comes in the cycle after acceptance.
- R8: Fetch address. After a command with a matching phase is accepted, fetch_addr equals cmd_addr. It then rises by one for each byte accepted.
- R9: Output stall. While out_valid is 1 and out_ready is 0, out_word holds steady and no byte is lost.
- R10: Clear. A one-cycle pulse on clr drops any held byte (hold_valid goes to 0) and ends any move in progress (cmd_ready goes to 1). It also empties the output register (out_valid goes to 0).
- R11: Busy. cmd_ready is 0 while a move with a nonzero count is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Abort the move and drop any held byte |
| cmd_valid | input | 1 | A move command is offered |
| cmd_ready | output | 1 | The block can accept a command |
| cmd_count | input | 24 | Byte count of the move |
| cmd_addr | input | 32 | Start address of the move |
| cmd_phase | input | 3 | Bus phase the move expects |
| cmd_chain | input | 1 | 1 = chained move, 0 = plain move |
| bus_phase | input | 3 | Current bus phase |
| in_valid | input | 1 | A memory byte is offered |
| in_ready | output | 1 | The byte is taken this cycle |
| in_byte | input | 8 | Memory byte |
| fetch_addr | output | 32 | Address of the next byte to fetch |
| out_valid | output | 1 | out_word holds a bus word |
| out_ready | input | 1 | The bus takes the word |
| out_word | output | 16 | Bus word, earlier byte in the low half |
| hold_valid | output | 1 | A residue byte is being held |
| pad_flag | output | 1 | The last plain move ended padded |
| done | output | 1 | Move finished (one-cycle pulse) |
| phase_irq | output | 1 | Phase mismatch interrupt (one-cycle pulse) |

## Verification
The assertions assume the following about the inputs:
- Command fields stay steady while cmd_valid waits for cmd_ready.
- A clear pulse and a byte handshake are not counted on to advance the address in the same cycle.
- Bytes are offered only while a move runs, and are otherwise ignored.

The stimulus drives each command and holds it until it is accepted. It offers a byte only after the command has been taken, except on purpose after a phase mismatch. There it keeps in_valid high for several cycles to show that no byte is taken. The command table is walked twice: the first time with out_ready held high, and the second time under pseudo-random output stalls. Held residues therefore cross stalled and unstalled word boundaries alike.

// File: rtl/mvpk_pkg.sv
package mvpk_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_MOVE = 1'b1} mv_state_t;
endpackage

// File: rtl/mvpk_ctrl.sv
module mvpk_ctrl
  import mvpk_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32,
  parameter int PH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [PH_W-1:0]   cmd_phase,
  input  logic              cmd_chain,
  input  logic [PH_W-1:0]   bus_phase,
  input  logic              take,
  output logic              active,
  output logic              chain,
  output logic              last,
  output logic              cmd_accept,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              done,
  output logic              phase_irq
);
  mv_state_t        st;
  logic [CNT_W-1:0] remain;
  logic             phase_ok;

  assign phase_ok   = (cmd_phase == bus_phase);
  assign cmd_ready  = (st == ST_IDLE);
  assign cmd_accept = cmd_valid && cmd_ready;
  assign active     = (st == ST_MOVE);
  assign last       = (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      remain     <= '0;
      chain      <= 1'b0;
      fetch_addr <= '0;
      done       <= 1'b0;
      phase_irq  <= 1'b0;
    end else if (clr) begin
      st        <= ST_IDLE;
      remain    <= '0;
      chain     <= 1'b0;
      done      <= 1'b0;
      phase_irq <= 1'b0;
    end else begin
      done      <= 1'b0;
      phase_irq <= 1'b0;
      if (cmd_accept) begin
        if (!phase_ok) begin
          phase_irq <= 1'b1;
        end else begin
          fetch_addr <= cmd_addr;
          chain      <= cmd_chain;
          if (cmd_count == '0) begin
            done <= 1'b1;
          end else begin
            st     <= ST_MOVE;
            remain <= cmd_count;
          end
        end
      end else if (active && take) begin
        remain     <= remain - CNT_W'(1);
        fetch_addr <= fetch_addr + ADDR_W'(1);
        if (last) begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
      end
    end
  end

  // R8: address advances by one per accepted byte
  p_addr_step_r8: assert property (@(posedge clk) disable iff (rst)
    (take && !clr) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1));
  // R6: a mismatch leaves the block idle
  p_irq_idle_r6: assert property (@(posedge clk) disable iff (rst)
    phase_irq |-> (cmd_ready && !done));
  // R7: done only once the move has ended
  p_done_ends_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !active);
  // R11: no byte is taken outside a move
  p_take_in_move_r11: assert property (@(posedge clk) disable iff (rst)
    take |-> active);
endmodule

// File: rtl/mvpk_pair.sv
module mvpk_pair #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                take,
  input  logic [BYTE_W-1:0]   in_byte,
  input  logic                last,
  input  logic                chain,
  input  logic                cmd_accept,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [2*BYTE_W-1:0] out_word,
  output logic                hold_valid,
  output logic                pad_flag
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      out_valid  <= 1'b0;
      out_word   <= '0;
      hold_valid <= 1'b0;
      lo_q       <= '0;
      pad_flag   <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (cmd_accept) pad_flag <= 1'b0;
      if (take) begin
        if (hold_valid) begin
          out_word   <= {in_byte, lo_q};
          out_valid  <= 1'b1;
          hold_valid <= 1'b0;
        end else if (last && !chain) begin
          out_word  <= {BYTE_W'(0), in_byte};
          out_valid <= 1'b1;
          pad_flag  <= 1'b1;
        end else begin
          lo_q       <= in_byte;
          hold_valid <= 1'b1;
        end
      end
    end
  end

  // R9: stalled word holds
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_word)));
  // R5: padded word carries a zero upper byte
  p_pad_zero_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(pad_flag) |-> (out_valid && out_word[WORD_W-1:BYTE_W] == '0));
  // R10: clear empties residue and output
  p_clr_drop_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!hold_valid && !out_valid));
endmodule

// File: rtl/oddbyte_word_packer.sv
module oddbyte_word_packer #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32,
  parameter int PH_W   = 3,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [CNT_W-1:0]    cmd_count,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [PH_W-1:0]     cmd_phase,
  input  logic                cmd_chain,
  input  logic [PH_W-1:0]     bus_phase,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [BYTE_W-1:0]   in_byte,
  output logic [ADDR_W-1:0]   fetch_addr,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2*BYTE_W-1:0] out_word,
  output logic                hold_valid,
  output logic                pad_flag,
  output logic                done,
  output logic                phase_irq
);
  logic active, chain, last, cmd_accept, take;

  assign in_ready = active && (!out_valid || out_ready);
  assign take     = in_valid && in_ready;

  mvpk_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .PH_W(PH_W)) u_ctrl (
    .clk(clk), .rst(rst), .clr(clr),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_count(cmd_count),
    .cmd_addr(cmd_addr), .cmd_phase(cmd_phase), .cmd_chain(cmd_chain),
    .bus_phase(bus_phase), .take(take), .active(active), .chain(chain),
    .last(last), .cmd_accept(cmd_accept), .fetch_addr(fetch_addr),
    .done(done), .phase_irq(phase_irq)
  );

  mvpk_pair #(.BYTE_W(BYTE_W)) u_pair (
    .clk(clk), .rst(rst), .clr(clr), .take(take), .in_byte(in_byte),
    .last(last), .chain(chain), .cmd_accept(cmd_accept),
    .out_ready(out_ready), .out_valid(out_valid), .out_word(out_word),
    .hold_valid(hold_valid), .pad_flag(pad_flag)
  );

  // R2: no byte enters while a full word is stuck
  p_no_overrun_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !take);
endmodule

// File: tb/sim_oddbyte_word_packer.sv
`timescale 1ns/1ps
module sim_oddbyte_word_packer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, clr = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, cmd_chain = 1'b0;
  logic [23:0] cmd_count = '0;
  logic [31:0] cmd_addr = '0, fetch_addr;
  logic [2:0] cmd_phase = '0, bus_phase = '0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_byte = '0;
  logic out_valid, out_ready = 1'b1;
  logic [15:0] out_word;
  logic hold_valid, pad_flag, done, phase_irq;

  oddbyte_word_packer u0 (.*);

  int n_chk = 0, n_fail = 0, dones = 0, irqs = 0, takes = 0;
  bit bp_en = 1'b0, finished = 1'b0, prev_stall = 1'b0;
  logic [15:0] prev_word = '0;
  logic [15:0] expq[$];
  logic [7:0] nb = 8'h01, mlo = '0, lf = 8'h5a;
  bit mhold = 1'b0, mpad = 1'b0;

  // count, chain, phase mismatch
  localparam logic [9:0] VEC [8] = '{
    {8'd5, 1'b1, 1'b0}, {8'd5, 1'b0, 1'b0}, {8'd3, 1'b0, 1'b0},
    {8'd4, 1'b1, 1'b0}, {8'd1, 1'b1, 1'b0}, {8'd0, 1'b1, 1'b0},
    {8'd1, 1'b0, 1'b1}, {8'd2, 1'b0, 1'b0}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    out_ready <= bp_en ? lf[0] : 1'b1;
  end

  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (prev_stall) chk(out_valid && out_word == prev_word, "R9 stalled word", out_word, prev_word);
      prev_stall = out_valid && !out_ready && !clr;
      prev_word  = out_word;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(1'b0, "R2 unexpected word", out_word, 0);
        else begin
          logic [15:0] e;
          e = expq.pop_front();
          chk(out_word == e, "R2/R4 word value", out_word, e);
        end
      end
      if (in_valid && in_ready) takes++;
      if (done) dones++;
      if (phase_irq) irqs++;
    end else prev_stall = 1'b0;
  end

  task automatic send_cmd(input int cnt, input bit ch, input bit mism, input logic [31:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_count = 24'(cnt); cmd_addr = a; cmd_chain = ch;
    cmd_phase = 3'd2; bus_phase = mism ? 3'd3 : 3'd2;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    mpad = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
  endtask

  task automatic feed_byte(input bit is_last, input bit ch);
    if (mhold) begin expq.push_back({nb, mlo}); mhold = 1'b0; end
    else if (is_last && !ch) begin expq.push_back({8'h00, nb}); mpad = 1'b1; end
    else begin mlo = nb; mhold = 1'b1; end
    @(negedge clk);
    in_valid = 1'b1; in_byte = nb;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    nb = nb + 8'd1;
  endtask

  task automatic run_cmd(input int cnt, input bit ch, input bit mism, input logic [31:0] a);
    int d0, i0, t0;
    bit h0;
    d0 = dones; i0 = irqs; t0 = takes; h0 = mhold;
    send_cmd(cnt, ch, mism, a);
    if (mism) begin
      chk(phase_irq == 1'b1, "R6 irq pulse", phase_irq, 1);
      @(negedge clk); in_valid = 1'b1; in_byte = 8'hee;
      repeat (3) @(negedge clk);
      in_valid = 1'b0;
      #1;
      chk(takes == t0, "R6 no byte taken", takes - t0, 0);
      chk(hold_valid == h0, "R6 hold unchanged", hold_valid, h0);
    end else if (cnt == 0) begin
      chk(done == 1'b1, "R7 zero-count done", done, 1);
    end else begin
      chk(fetch_addr == a, "R8 start address", fetch_addr, a);
      chk(cmd_ready == 1'b0, "R11 busy", cmd_ready, 0);
      for (int k = 0; k < cnt; k++) feed_byte(k == cnt - 1, ch);
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      chk(done == 1'b1, "R7 done after last byte", done, 1);
    end
    for (int w = 0; w < 80 && expq.size() != 0; w++) @(negedge clk);
    repeat (2) @(negedge clk);
    #1;
    chk(expq.size() == 0, "R2 all words out", expq.size(), 0);
    chk(dones - d0 == (mism ? 0 : 1), "R7 done count", dones - d0, mism ? 0 : 1);
    chk(irqs - i0 == (mism ? 1 : 0), "R6 irq count", irqs - i0, mism ? 1 : 0);
    chk(hold_valid == mhold, "R3 hold state", hold_valid, mhold);
    chk(pad_flag == mpad, "R5 pad flag", pad_flag, mpad);
    if (!mism) chk(fetch_addr == a + 32'(cnt), "R8 end address", fetch_addr, a + 32'(cnt));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk(!out_valid && !hold_valid && !pad_flag, "R1 outputs idle", {out_valid, hold_valid, pad_flag}, 0);
    chk(!done && !phase_irq, "R1 no pulses", {done, phase_irq}, 0);
    chk(cmd_ready && !in_ready, "R1 ready state", {cmd_ready, in_ready}, 2'b10);

    for (int pass = 0; pass < 2; pass++) begin
      bp_en = (pass == 1);
      for (int i = 0; i < 8; i++)
        run_cmd(int'(VEC[i][9:2]), VEC[i][1], VEC[i][0], 32'h1000_0000 + 32'(i) * 32'h100);
    end
    bp_en = 1'b0;

    // R10: clear drops a held residue
    run_cmd(3, 1'b1, 1'b0, 32'h2000_0000);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    #1;
    chk(hold_valid == 1'b0, "R10 residue dropped", hold_valid, 0);
    mhold = 1'b0;

    // R10: clear aborts a move part way through
    send_cmd(4, 1'b0, 1'b0, 32'h3000_0000);
    feed_byte(1'b0, 1'b0);
    @(negedge clk); in_valid = 1'b0; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    #1;
    mhold = 1'b0;
    chk(cmd_ready == 1'b1, "R10 move aborted", cmd_ready, 1);
    chk(!out_valid && !hold_valid, "R10 output empty", {out_valid, hold_valid}, 0);

    // R4: after clear, pairing restarts with no residue
    run_cmd(2, 1'b0, 1'b0, 32'h4000_0000);
    summary();
  end
endmodule